// File: doc/BRIEF.md
# DAC Output-Stage Power Mode Controller

This block holds the power state of a single-channel voltage-output DAC and drives its output-stage control lines. A serial front end, which lies outside the block, hands it complete frames. Each frame is a command byte plus a 16-bit payload, marked by a one-cycle valid strobe. The block keeps the DAC code register and a staging register. It tracks which of five operating modes is active: two active modes (low power or fast settling) and three power-down terminations (1 kΩ to ground, 100 kΩ to ground, or high impedance).

A payload is either a data word or a power word. It can be applied at once, parked in the staging register, or applied later from the staging register. Parking power words lets several converters on one bus be switched off by a single common load. A data update always brings the output back from power-down into the last active mode. That return starts a wake timer, and a settling flag stays high until the timer expires.

Top module: `dacpwr_ctrl`

## Requirements
- R1: Reset (`rst` high, synchronous) puts the block in low-power mode, clears the DAC code, the staging register and its power-word tag, and drops `settling`.
- R2: A power word is applied when command bit 0 is 1. Its mode field is payload bits [15:13]. Field 000 selects low-power mode (`amp_en`=1, `fast_bias`=0). Field 001 selects fast-settling mode (`amp_en`=1, `fast_bias`=1).
- R3: Field 010 selects power-down with `gnd_1k`. Field 011 selects power-down with `gnd_100k`. Any field with bit 15 set selects `hiz`, and bits [14:13] are then ignored.
- R4: Exactly one of `amp_en`, `gnd_1k`, `gnd_100k`, `hiz` is high at all times. `fast_bias` is high only in fast-settling mode.
- R5: An applied data word (command bit 0 = 0) loads `dac_code`. If the block is powered down, the data word also returns it to the last active mode (low power or fast settling), which a data word never changes.
- R6: Power words and power-down never alter `dac_code`.
- R7: Load field = command bits [5:4]. Value 00 stores the payload and its bit-0 tag in the staging register without changing any output. Value 01 applies the payload at once.
- R8: Load field 10 applies the staging register contents, either as a data word or as a power word according to the stored tag, and ignores the frame's own payload.
- R9: Each change from power-down to an active mode holds `settling` high for exactly `WAKE_CYCLES` cycles, starting the cycle after the frame.
- R10: Entering power-down clears `settling` at once.
- R11: Load field 11, an idle strobe, and command bits 7:6 and 3:1 have no effect.
- R12: Switching between the two active modes does not raise `settling`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_valid | input | 1 | One-cycle strobe: frame present |
| frm_ctl | input | 8 | Command byte (bit 0 power tag, bits 5:4 load field) |
| frm_data | input | 16 | Payload: DAC code or power word (mode in bits 15:13) |
| dac_code | output | 16 | Current DAC code register |
| amp_en | output | 1 | Output amplifier enabled (active mode) |
| fast_bias | output | 1 | Fast-settling bias enabled |
| gnd_1k | output | 1 | Output terminated to ground through 1 kΩ |
| gnd_100k | output | 1 | Output terminated to ground through 100 kΩ |
| hiz | output | 1 | Output left high impedance |
| settling | output | 1 | Wake timer running after leaving power-down |

## Verification
The bench sweeps all eight mode-field values from both active modes. It then wakes the block with a data word and watches the wake timer count down to the exact cycle. A design that forgot the active-mode choice would wake fast-settling parts into low power. A design that decoded bits [14:13] under bit 15 would pick a resistor instead of high impedance. The bench also covers re-entry to power-down during settling, staged power words applied later, a staging register left dirty across reset, and every command byte value. A decoder that looked at more than the load field and tag bit would then change state on a frame that must be ignored.

// File: rtl/dacpwr_pkg.sv
package dacpwr_pkg;

    typedef enum logic [2:0] {
        PM_LOW     = 3'd0,
        PM_FAST    = 3'd1,
        PM_PD_1K   = 3'd2,
        PM_PD_100K = 3'd3,
        PM_PD_HIZ  = 3'd4
    } pmode_e;

    typedef enum logic [1:0] {
        LD_STAGE  = 2'b00,
        LD_DIRECT = 2'b01,
        LD_STAGED = 2'b10,
        LD_RSVD   = 2'b11
    } load_e;

    typedef struct packed {
        logic amp_en;
        logic fast_bias;
        logic gnd_1k;
        logic gnd_100k;
        logic hiz;
    } ostage_t;

    localparam int PWR_FIELD_W = 3;

    function automatic pmode_e decode_pword(input logic [PWR_FIELD_W-1:0] m);
        pmode_e r;
        if (m[2]) begin
            r = PM_PD_HIZ;
        end else begin
            case (m[1:0])
                2'b00:   r = PM_LOW;
                2'b01:   r = PM_FAST;
                2'b10:   r = PM_PD_1K;
                default: r = PM_PD_100K;
            endcase
        end
        return r;
    endfunction

    function automatic logic is_pd(input pmode_e m);
        return (m == PM_PD_1K) || (m == PM_PD_100K) || (m == PM_PD_HIZ);
    endfunction

    function automatic ostage_t drive_of(input pmode_e m);
        ostage_t o;
        o.amp_en    = (m == PM_LOW) || (m == PM_FAST);
        o.fast_bias = (m == PM_FAST);
        o.gnd_1k    = (m == PM_PD_1K);
        o.gnd_100k  = (m == PM_PD_100K);
        o.hiz       = (m == PM_PD_HIZ);
        return o;
    endfunction

endpackage

// File: rtl/dacpwr_cmd_decode.sv
module dacpwr_cmd_decode
    import dacpwr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              frm_valid,
    input  logic [7:0]        frm_ctl,
    input  logic [DATA_W-1:0] frm_data,
    input  logic              stg_pwr,
    input  logic [DATA_W-1:0] stg_word,
    output logic              stg_we,
    output logic              stg_pwr_nxt,
    output logic [DATA_W-1:0] stg_word_nxt,
    output logic              apply,
    output logic              apply_pwr,
    output logic [DATA_W-1:0] apply_word
);

    load_e ld;
    logic  unused_ctl_bits;

    assign ld              = load_e'(frm_ctl[5:4]);
    assign unused_ctl_bits = ^{frm_ctl[7:6], frm_ctl[3:1]};

    always_comb begin
        stg_we       = 1'b0;
        stg_pwr_nxt  = frm_ctl[0];
        stg_word_nxt = frm_data;
        apply        = 1'b0;
        apply_pwr    = 1'b0;
        apply_word   = frm_data;
        if (frm_valid) begin
            case (ld)
                LD_STAGE: begin
                    stg_we = 1'b1;
                end
                LD_DIRECT: begin
                    apply     = 1'b1;
                    apply_pwr = frm_ctl[0];
                end
                LD_STAGED: begin
                    apply      = 1'b1;
                    apply_pwr  = stg_pwr;
                    apply_word = stg_word;
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/dacpwr_stage_reg.sv
module dacpwr_stage_reg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              pwr_in,
    input  logic [DATA_W-1:0] word_in,
    output logic              pwr_q,
    output logic [DATA_W-1:0] word_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pwr_q  <= 1'b0;
            word_q <= '0;
        end else if (we) begin
            pwr_q  <= pwr_in;
            word_q <= word_in;
        end
    end

endmodule

// File: rtl/dacpwr_mode_fsm.sv
module dacpwr_mode_fsm
    import dacpwr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              apply,
    input  logic              apply_pwr,
    input  logic [DATA_W-1:0] apply_word,
    output pmode_e            mode,
    output logic [DATA_W-1:0] dac_code,
    output logic              wake_start,
    output logic              pd_enter
);

    localparam int FIELD_LSB = DATA_W - PWR_FIELD_W;

    pmode_e            mode_q, mode_d;
    logic              fast_q, fast_d;
    logic [DATA_W-1:0] dac_q, dac_d;
    pmode_e            req;

    assign req = decode_pword(apply_word[DATA_W-1:FIELD_LSB]);

    always_comb begin
        mode_d     = mode_q;
        fast_d     = fast_q;
        dac_d      = dac_q;
        wake_start = 1'b0;
        pd_enter   = 1'b0;
        if (apply) begin
            if (!apply_pwr) begin
                dac_d = apply_word;
                if (is_pd(mode_q)) begin
                    mode_d     = fast_q ? PM_FAST : PM_LOW;
                    wake_start = 1'b1;
                end
            end else if (is_pd(req)) begin
                mode_d   = req;
                pd_enter = 1'b1;
            end else begin
                mode_d     = req;
                fast_d     = (req == PM_FAST);
                wake_start = is_pd(mode_q);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= PM_LOW;
            fast_q <= 1'b0;
            dac_q  <= '0;
        end else begin
            mode_q <= mode_d;
            fast_q <= fast_d;
            dac_q  <= dac_d;
        end
    end

    assign mode     = mode_q;
    assign dac_code = dac_q;

endmodule

// File: rtl/dacpwr_wake_timer.sv
module dacpwr_wake_timer #(
    parameter int WAKE_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic abort,
    output logic busy
);

    localparam int CNT_W = $clog2(WAKE_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CNT_W'(WAKE_CYCLES);
        end else if (abort) begin
            cnt_q <= '0;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/dacpwr_ctrl.sv
module dacpwr_ctrl
    import dacpwr_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int WAKE_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frm_valid,
    input  logic [7:0]        frm_ctl,
    input  logic [DATA_W-1:0] frm_data,
    output logic [DATA_W-1:0] dac_code,
    output logic              amp_en,
    output logic              fast_bias,
    output logic              gnd_1k,
    output logic              gnd_100k,
    output logic              hiz,
    output logic              settling
);

    logic              stg_we, stg_pwr_nxt, stg_pwr;
    logic [DATA_W-1:0] stg_word_nxt, stg_word;
    logic              apply, apply_pwr;
    logic [DATA_W-1:0] apply_word;
    pmode_e            mode;
    logic              wake_start, pd_enter;
    ostage_t           drv;

    dacpwr_cmd_decode #(.DATA_W(DATA_W)) dec_i (
        .frm_valid   (frm_valid),
        .frm_ctl     (frm_ctl),
        .frm_data    (frm_data),
        .stg_pwr     (stg_pwr),
        .stg_word    (stg_word),
        .stg_we      (stg_we),
        .stg_pwr_nxt (stg_pwr_nxt),
        .stg_word_nxt(stg_word_nxt),
        .apply       (apply),
        .apply_pwr   (apply_pwr),
        .apply_word  (apply_word)
    );

    dacpwr_stage_reg #(.DATA_W(DATA_W)) stg_i (
        .clk    (clk),
        .rst    (rst),
        .we     (stg_we),
        .pwr_in (stg_pwr_nxt),
        .word_in(stg_word_nxt),
        .pwr_q  (stg_pwr),
        .word_q (stg_word)
    );

    dacpwr_mode_fsm #(.DATA_W(DATA_W)) fsm_i (
        .clk       (clk),
        .rst       (rst),
        .apply     (apply),
        .apply_pwr (apply_pwr),
        .apply_word(apply_word),
        .mode      (mode),
        .dac_code  (dac_code),
        .wake_start(wake_start),
        .pd_enter  (pd_enter)
    );

    dacpwr_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) wake_i (
        .clk  (clk),
        .rst  (rst),
        .start(wake_start),
        .abort(pd_enter),
        .busy (settling)
    );

    assign drv       = drive_of(mode);
    assign amp_en    = drv.amp_en;
    assign fast_bias = drv.fast_bias;
    assign gnd_1k    = drv.gnd_1k;
    assign gnd_100k  = drv.gnd_100k;
    assign hiz       = drv.hiz;

endmodule

// File: rtl/dacpwr_ctrl_chk.sv
module dacpwr_ctrl_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              frm_valid,
    input logic [7:0]        frm_ctl,
    input logic [DATA_W-1:0] frm_data,
    input logic [DATA_W-1:0] dac_code,
    input logic              amp_en,
    input logic              fast_bias,
    input logic              gnd_1k,
    input logic              gnd_100k,
    input logic              hiz,
    input logic              settling
);

    logic unused_data;
    assign unused_data = ^frm_data;

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (amp_en && !fast_bias && !settling && dac_code == '0));

    assert_one_termination_R4: assert property (@(posedge clk) disable iff (rst)
        $countones({amp_en, gnd_1k, gnd_100k, hiz}) == 1);

    assert_fast_needs_amp_R4: assert property (@(posedge clk) disable iff (rst)
        fast_bias |-> amp_en);

    assert_data_wakes_R5: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && frm_ctl[5:4] == 2'b01 && !frm_ctl[0] && !amp_en) |=> amp_en);

    assert_pword_keeps_code_R6: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && frm_ctl[5:4] == 2'b01 && frm_ctl[0]) |=> $stable(dac_code));

    assert_stage_no_effect_R7: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && frm_ctl[5:4] == 2'b00) |=>
            ($stable(dac_code) && $stable({amp_en, fast_bias, gnd_1k, gnd_100k, hiz})));

    assert_wake_sets_settling_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(amp_en) |-> settling);

    assert_settling_only_active_R9: assert property (@(posedge clk) disable iff (rst)
        settling |-> amp_en);

    assert_pd_clears_settling_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(amp_en) |-> !settling);

    assert_reserved_ignored_R11: assert property (@(posedge clk) disable iff (rst)
        (!frm_valid || frm_ctl[5:4] == 2'b11) |=>
            ($stable(dac_code) && $stable({amp_en, fast_bias, gnd_1k, gnd_100k, hiz})));

    assert_active_swap_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        ($past(amp_en) && amp_en && !$past(settling)) |-> !settling);

endmodule

bind dacpwr_ctrl dacpwr_ctrl_chk #(.DATA_W(DATA_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .frm_valid(frm_valid),
    .frm_ctl  (frm_ctl),
    .frm_data (frm_data),
    .dac_code (dac_code),
    .amp_en   (amp_en),
    .fast_bias(fast_bias),
    .gnd_1k   (gnd_1k),
    .gnd_100k (gnd_100k),
    .hiz      (hiz),
    .settling (settling)
);

// File: tb/dacpwr_ctrl_tb.sv
module dacpwr_ctrl_tb_top;

    localparam int W = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frm_valid = 1'b0;
    logic [7:0]  frm_ctl = '0;
    logic [15:0] frm_data = '0;
    logic [15:0] dac_code;
    logic        amp_en, fast_bias, gnd_1k, gnd_100k, hiz, settling;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int          m_mode;
    bit          m_fast;
    logic [15:0] m_dac;
    bit          m_stp;
    logic [15:0] m_stw;
    int          m_cnt;

    always #2 clk = ~clk;

    dacpwr_ctrl #(.DATA_W(16), .WAKE_CYCLES(W)) dut_i (
        .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_ctl(frm_ctl),
        .frm_data(frm_data), .dac_code(dac_code), .amp_en(amp_en),
        .fast_bias(fast_bias), .gnd_1k(gnd_1k), .gnd_100k(gnd_100k),
        .hiz(hiz), .settling(settling)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "dac_code", int'(dac_code), int'(m_dac));
        chk(tag, "amp_en", int'(amp_en), int'(m_mode < 2));
        chk(tag, "fast_bias", int'(fast_bias), int'(m_mode == 1));
        chk(tag, "gnd_1k", int'(gnd_1k), int'(m_mode == 2));
        chk(tag, "gnd_100k", int'(gnd_100k), int'(m_mode == 3));
        chk(tag, "hiz", int'(hiz), int'(m_mode == 4));
        chk(tag, "settling", int'(settling), int'(m_cnt != 0));
    endtask

    task automatic model_reset();
        m_mode = 0; m_fast = 0; m_dac = '0; m_stp = 0; m_stw = '0; m_cnt = 0;
    endtask

    task automatic model_apply(input bit pw, input logic [15:0] d,
                               output bit st, output bit en);
        int req;
        st = 0; en = 0;
        req = (d[15] == 1'b1) ? 4 : int'(d[14:13]);
        if (!pw) begin
            m_dac = d;
            if (m_mode >= 2) begin
                m_mode = m_fast ? 1 : 0;
                st = 1;
            end
        end else if (req >= 2) begin
            m_mode = req;
            en = 1;
        end else begin
            st = (m_mode >= 2);
            m_mode = req;
            m_fast = (req == 1);
        end
    endtask

    task automatic model_step(input bit v, input logic [7:0] c, input logic [15:0] d);
        bit st, en;
        st = 0; en = 0;
        if (v) begin
            case (c[5:4])
                2'b00: begin m_stp = c[0]; m_stw = d; end
                2'b01: model_apply(c[0], d, st, en);
                2'b10: model_apply(m_stp, m_stw, st, en);
                default: ;
            endcase
        end
        if (st) m_cnt = W;
        else if (en) m_cnt = 0;
        else if (m_cnt > 0) m_cnt = m_cnt - 1;
    endtask

    task automatic step(input bit v, input logic [7:0] c, input logic [15:0] d, input string tag);
        frm_valid = v; frm_ctl = c; frm_data = d;
        @(posedge clk);
        model_step(v, c, d);
        @(negedge clk);
        frm_valid = 1'b0;
        check_all(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 8'h00, 16'h0000, tag);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk); @(posedge clk);
        model_reset();
        @(negedge clk);
        rst = 1'b0;
        check_all("R1");
    endtask

    initial begin
        @(negedge clk);
        do_reset();

        // R2 R3 R5 R6 R9: every mode field from both active modes, then wake by data
        for (int pre = 0; pre < 2; pre++) begin
            for (int m = 0; m < 8; m++) begin
                do_reset();
                if (pre == 1) step(1'b1, 8'h11, 16'h2000, "R2");
                step(1'b1, 8'h10, 16'hA5A5 ^ 16'(m * 257), "R5");
                step(1'b1, 8'h11, {3'(m), 13'(m * 1111 + 7)}, (m < 2) ? "R2" : "R3");
                step(1'b1, 8'h11, {3'(m), 13'h1FFF}, "R6");
                step(1'b1, 8'h10, 16'h0F0F + 16'(m), "R5");
                idle(W + 2, "R9");
            end
        end

        // R7 R8: staged power word and staged data
        do_reset();
        step(1'b1, 8'h01, 16'h4000, "R7");
        step(1'b1, 8'h10, 16'h1357, "R7");
        step(1'b1, 8'h20, 16'hFFFF, "R8");
        step(1'b1, 8'h00, 16'hBEEF, "R7");
        step(1'b1, 8'h20, 16'h0000, "R8");
        idle(W + 1, "R9");
        step(1'b1, 8'h01, 16'hE000, "R7");
        step(1'b1, 8'h20, 16'h0000, "R8");
        step(1'b1, 8'h20, 16'h0000, "R8");

        // R10: power-down again while settling
        step(1'b1, 8'h10, 16'h2222, "R5");
        idle(2, "R9");
        step(1'b1, 8'h11, 16'h6000, "R10");
        idle(2, "R10");

        // R12: active mode swap never raises settling
        step(1'b1, 8'h11, 16'h0000, "R9");
        idle(W + 1, "R9");
        step(1'b1, 8'h11, 16'h2000, "R12");
        step(1'b1, 8'h11, 16'h0000, "R12");

        // R4 R11: every command byte value
        for (int c = 0; c < 256; c++) begin
            step(1'b1, 8'(c), {8'(c), 8'(c) ^ 8'h5A}, (c[5:4] == 2'b11) ? "R11" : "R4");
            if (c % 3 == 0) idle(1, "R11");
        end

        // R1: reset clears staging register
        step(1'b1, 8'h01, 16'h8000, "R7");
        step(1'b1, 8'h10, 16'h7777, "R5");
        do_reset();
        step(1'b1, 8'h10, 16'h1234, "R5");
        step(1'b1, 8'h20, 16'h5555, "R1");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule